// File: doc/BRIEF.md
# Machine-Level Interrupt Pending/Enable Arbiter

This block holds the interrupt pending and interrupt enable words for a hart that has user, supervisor and machine modes. Each mode has three interrupt kinds: external, software and timer. Four pending bits copy level inputs every cycle. These are the external line for each of the three modes and the machine timer line. The software-interrupt and lower-mode timer bits are set and cleared through a CSR write port. The machine software bit is driven by a separate memory-mapped inter-processor-interrupt write port.

Every cycle the block gates each pending-and-enabled interrupt by the privilege mode of the hart, using the per-mode global enable bits. It then picks one winner in a fixed order. It registers a take request with a cause code. If nothing is eligible but a synchronous exception is pending, it registers an exception-go flag instead. The trap controller samples these registered outputs. The interrupt controller and the timer comparator that produce the level inputs sit outside the block.

Bit positions of both words are the cause codes:

| Cause | Interrupt |
|---|---|
| 0 | user software |
| 1 | supervisor software |
| 3 | machine software |
| 4 | user timer |
| 5 | supervisor timer |
| 7 | machine timer |
| 8 | user external |
| 9 | supervisor external |
| 11 | machine external |

Mode encoding is U=0, S=1, M=3.

Top module: `irq_arbiter`

## Requirements
- R1: While rst_n is low, and at the first sample after reset, the pending word, the enable word, take_irq, irq_cause and exc_go are all zero, provided all input lines are low.
- R2: These pending bits copy their level inputs one clock later:
  - bit 11 copies ext_m_line
  - bit 9 copies ext_s_line
  - bit 8 copies ext_u_line
  - bit 7 copies mtimer_line

  A CSR write to the pending word (csr_sel=0) never changes these four bits.
- R3: Which pending bits a CSR write (csr_we=1, csr_sel=0) may change depends on priv_mode:
  - M mode: bits 0, 1, 4 and 5 are loaded from csr_wdata.
  - S mode: only bits 0 and 1 are loaded.
  - U mode: the write has no effect.

  Bit 3 is never changed through this port.
- R4: An inter-processor-interrupt write (ipi_we=1) loads ipi_wdata into pending bit 3 at the next clock.
- R5: A CSR write to the enable word (csr_sel=1) made in M mode loads csr_wdata masked to bits 0,1,3,4,5,7,8,9,11. Bits outside that set always read 0. Enable writes made in S or U mode have no effect.
- R6: An interrupt is eligible only when its pending bit and its enable bit are both set, and its target mode allows it:
  - Target mode above the current mode: always allowed.
  - Target mode equal to the current mode: allowed only if that mode's global enable bit is set (glb_ie bit 0 = U, bit 1 = S, bit 2 = M).
  - Target mode below the current mode: never allowed.
- R7: Among eligible interrupts the winner is chosen by kind first, then by target mode. External beats software, and software beats timer. Within one kind, M beats S and S beats U. This gives the order 11, 9, 8, 3, 1, 0, 7, 5, 4.
- R8: take_irq and irq_cause are registered. They reflect the eligibility conditions present before the previous rising edge and hold for a full cycle. A change on an input line therefore reaches take_irq two clocks later, and a change on priv_mode or glb_ie reaches it one clock later.
- R9: exc_go is set one clock after exc_pending is high while no interrupt is eligible. It is suppressed whenever any interrupt is eligible. take_irq and exc_go are never high together.
- R10: When take_irq is low, irq_cause reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| priv_mode | input | 2 | Current privilege mode (U=0, S=1, M=3) |
| glb_ie | input | 3 | Per-mode global interrupt enable (bit0 U, bit1 S, bit2 M) |
| ext_m_line | input | 1 | Machine external interrupt level |
| ext_s_line | input | 1 | Supervisor external interrupt level |
| ext_u_line | input | 1 | User external interrupt level |
| mtimer_line | input | 1 | Machine timer interrupt level |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 1 | CSR write target: 0 pending word, 1 enable word |
| csr_wdata | input | 12 | CSR write data |
| ipi_we | input | 1 | Inter-processor-interrupt write strobe |
| ipi_wdata | input | 1 | Value loaded into machine software pending bit |
| exc_pending | input | 1 | Synchronous exception waiting to be taken |
| pend_o | output | 12 | Current pending word |
| ena_o | output | 12 | Current enable word |
| take_irq | output | 1 | Registered interrupt take request |
| irq_cause | output | 4 | Registered cause code of the winner |
| exc_go | output | 1 | Registered exception-proceeds flag |

## Verification
The hardest situation to reach is a full priority ladder. In it, several kinds are pending at several target modes at once, while the mode gating hides some of them. Every tier has to be observed as the winner in turn. The bench drives all lines high, loads the writable pending bits and raises the inter-processor bit from user mode with user interrupts globally disabled. It then removes one source, or flips one global enable, per step. After each step it waits the two register stages before sampling, so each lower tier surfaces in the documented order.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int IRQ_W   = 12;
    localparam int CAUSE_W = $clog2(IRQ_W);
    localparam int MODE_W  = 2;
    localparam int NMODES  = 3;

    localparam logic [MODE_W-1:0] MODE_U = 2'd0;
    localparam logic [MODE_W-1:0] MODE_S = 2'd1;
    localparam logic [MODE_W-1:0] MODE_M = 2'd3;

    localparam int BASE_SW  = 0;
    localparam int BASE_TMR = 4;
    localparam int BASE_EXT = 8;

    localparam int BIT_MSW  = BASE_SW  + 3;
    localparam int BIT_MTMR = BASE_TMR + 3;
    localparam int BIT_UEXT = BASE_EXT + 0;
    localparam int BIT_SEXT = BASE_EXT + 1;
    localparam int BIT_MEXT = BASE_EXT + 3;

    localparam logic [IRQ_W-1:0] IMPL_MASK = 12'hBBB;
    localparam logic [IRQ_W-1:0] LINE_MASK = 12'hB80;
    localparam logic [IRQ_W-1:0] M_WR_MASK = 12'h033;
    localparam logic [IRQ_W-1:0] S_WR_MASK = 12'h003;

    typedef struct packed {
        logic [IRQ_W-1:0] pend;
        logic [IRQ_W-1:0] ena;
    } irq_regs_t;

    typedef struct packed {
        logic               take;
        logic [CAUSE_W-1:0] cause;
        logic               exc;
    } irq_sel_t;

    function automatic int glb_idx(input int tgt);
        return (tgt == 3) ? 2 : tgt;
    endfunction
endpackage

// File: rtl/irq_csr_regs.sv
module irq_csr_regs
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] priv_mode,
    input  logic              ext_m_line,
    input  logic              ext_s_line,
    input  logic              ext_u_line,
    input  logic              mtimer_line,
    input  logic              csr_we,
    input  logic              csr_sel,
    input  logic [IRQ_W-1:0]  csr_wdata,
    input  logic              ipi_we,
    input  logic              ipi_wdata,
    output logic [IRQ_W-1:0]  pend_q_o,
    output logic [IRQ_W-1:0]  ena_q_o
);
    irq_regs_t regs_d, regs_q;
    logic [IRQ_W-1:0] line_vec;
    logic [IRQ_W-1:0] wr_mask;

    always_comb begin
        line_vec           = '0;
        line_vec[BIT_MEXT] = ext_m_line;
        line_vec[BIT_SEXT] = ext_s_line;
        line_vec[BIT_UEXT] = ext_u_line;
        line_vec[BIT_MTMR] = mtimer_line;

        unique case (priv_mode)
            MODE_M:  wr_mask = M_WR_MASK;
            MODE_S:  wr_mask = S_WR_MASK;
            default: wr_mask = '0;
        endcase

        regs_d      = regs_q;
        regs_d.pend = (regs_q.pend & ~LINE_MASK) | (line_vec & LINE_MASK);
        if (csr_we && !csr_sel) begin
            regs_d.pend = (regs_d.pend & ~wr_mask) | (csr_wdata & wr_mask);
        end
        if (ipi_we) begin
            regs_d.pend[BIT_MSW] = ipi_wdata;
        end
        if (csr_we && csr_sel && priv_mode == MODE_M) begin
            regs_d.ena = csr_wdata & IMPL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign pend_q_o = regs_q.pend;
    assign ena_q_o  = regs_q.ena;

    a_r2_mtimer_follow: assert property (@(posedge clk) disable iff (!rst_n)
        mtimer_line |=> pend_q_o[BIT_MTMR]);
    a_r2_mext_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_m_line |=> !pend_q_o[BIT_MEXT]);
    a_r4_ipi_load: assert property (@(posedge clk) disable iff (!rst_n)
        ipi_we |=> (pend_q_o[BIT_MSW] == $past(ipi_wdata)));
    a_r5_ena_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_sel && priv_mode != MODE_M) |=> $stable(ena_q_o));
    a_r5_ena_impl: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_q_o & ~IMPL_MASK) == '0);
endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_pkg::*;
(
    input  logic [IRQ_W-1:0]  pend,
    input  logic [IRQ_W-1:0]  ena,
    input  logic [MODE_W-1:0] priv_mode,
    input  logic [NMODES-1:0] glb_ie,
    output logic [IRQ_W-1:0]  cand
);
    localparam int MODE_SLOTS = 4;
    logic [MODE_SLOTS-1:0] mode_ok;

    always_comb begin
        for (int t = 0; t < MODE_SLOTS; t++) begin
            if (t == 2) begin
                mode_ok[t] = 1'b0;
            end else if (MODE_W'(t) > priv_mode) begin
                mode_ok[t] = 1'b1;
            end else if (MODE_W'(t) == priv_mode) begin
                mode_ok[t] = glb_ie[glb_idx(t)];
            end else begin
                mode_ok[t] = 1'b0;
            end
        end
    end

    for (genvar i = 0; i < IRQ_W; i++) begin : g_cand
        assign cand[i] = pend[i] & ena[i] & mode_ok[i % MODE_SLOTS];
    end
endmodule

// File: rtl/irq_prio.sv
module irq_prio
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IRQ_W-1:0]   cand,
    input  logic               exc_pending,
    output logic               take_q_o,
    output logic [CAUSE_W-1:0] cause_q_o,
    output logic               exc_q_o
);
    localparam int NKINDS = 3;
    irq_sel_t sel_d, sel_q;

    always_comb begin
        int base;
        sel_d = '0;
        for (int k = 0; k < NKINDS; k++) begin
            base = (k == 0) ? BASE_TMR : (k == 1) ? BASE_SW : BASE_EXT;
            for (int m = 0; m < 4; m++) begin
                if (m != 2 && cand[base + m]) begin
                    sel_d.take  = 1'b1;
                    sel_d.cause = CAUSE_W'(base + m);
                end
            end
        end
        sel_d.exc = exc_pending && !sel_d.take;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign take_q_o  = sel_q.take;
    assign cause_q_o = sel_q.cause;
    assign exc_q_o   = sel_q.exc;

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_q_o && exc_q_o));
    a_r9_exc_source: assert property (@(posedge clk) disable iff (!rst_n)
        exc_q_o |-> $past(exc_pending));
    a_r7_mext_first: assert property (@(posedge clk) disable iff (!rst_n)
        cand[BIT_MEXT] |=> (take_q_o && cause_q_o == CAUSE_W'(BIT_MEXT)));
    a_r10_idle_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !take_q_o |-> (cause_q_o == '0));
    a_r8_take_needs_cand: assert property (@(posedge clk) disable iff (!rst_n)
        (cand == '0) |=> !take_q_o);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          priv_mode,
    input  logic [2:0]          glb_ie,
    input  logic                ext_m_line,
    input  logic                ext_s_line,
    input  logic                ext_u_line,
    input  logic                mtimer_line,
    input  logic                csr_we,
    input  logic                csr_sel,
    input  logic [11:0]         csr_wdata,
    input  logic                ipi_we,
    input  logic                ipi_wdata,
    input  logic                exc_pending,
    output logic [11:0]         pend_o,
    output logic [11:0]         ena_o,
    output logic                take_irq,
    output logic [3:0]          irq_cause,
    output logic                exc_go
);
    logic [IRQ_W-1:0] pend_w, ena_w, cand_w;

    irq_csr_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .priv_mode   (priv_mode),
        .ext_m_line  (ext_m_line),
        .ext_s_line  (ext_s_line),
        .ext_u_line  (ext_u_line),
        .mtimer_line (mtimer_line),
        .csr_we      (csr_we),
        .csr_sel     (csr_sel),
        .csr_wdata   (csr_wdata),
        .ipi_we      (ipi_we),
        .ipi_wdata   (ipi_wdata),
        .pend_q_o    (pend_w),
        .ena_q_o     (ena_w)
    );

    irq_gate u_gate (
        .pend      (pend_w),
        .ena       (ena_w),
        .priv_mode (priv_mode),
        .glb_ie    (glb_ie),
        .cand      (cand_w)
    );

    irq_prio u_prio (
        .clk         (clk),
        .rst_n       (rst_n),
        .cand        (cand_w),
        .exc_pending (exc_pending),
        .take_q_o    (take_irq),
        .cause_q_o   (irq_cause),
        .exc_q_o     (exc_go)
    );

    assign pend_o = pend_w;
    assign ena_o  = ena_w;

    a_r6_below_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_mode == MODE_M) |-> (cand_w & 12'h333) == '0);
endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  priv_mode;
    logic [2:0]  glb_ie;
    logic        ext_m_line, ext_s_line, ext_u_line, mtimer_line;
    logic        csr_we, csr_sel;
    logic [11:0] csr_wdata;
    logic        ipi_we, ipi_wdata, exc_pending;
    logic [11:0] pend_o, ena_o;
    logic        take_irq;
    logic [3:0]  irq_cause;
    logic        exc_go;

    int n_vec = 0;
    int n_bad = 0;

    localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

    always #5 clk = ~clk;

    irq_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .glb_ie(glb_ie),
        .ext_m_line(ext_m_line), .ext_s_line(ext_s_line), .ext_u_line(ext_u_line),
        .mtimer_line(mtimer_line), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .ipi_we(ipi_we), .ipi_wdata(ipi_wdata),
        .exc_pending(exc_pending), .pend_o(pend_o), .ena_o(ena_o),
        .take_irq(take_irq), .irq_cause(irq_cause), .exc_go(exc_go)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_sel(input string tag, input logic t, input logic [3:0] c);
        chk({tag, " take"}, {31'd0, take_irq}, {31'd0, t});
        chk({tag, " cause"}, {28'd0, irq_cause}, {28'd0, c});
    endtask

    task automatic do_reset();
        rst_n = 1'b0; priv_mode = PU; glb_ie = 3'b000;
        ext_m_line = 0; ext_s_line = 0; ext_u_line = 0; mtimer_line = 0;
        csr_we = 0; csr_sel = 0; csr_wdata = '0;
        ipi_we = 0; ipi_wdata = 0; exc_pending = 0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic csr_wr(input logic sel, input logic [1:0] p, input logic [11:0] d);
        logic [1:0] old;
        old = priv_mode;
        priv_mode = p; csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
        tick(1);
        csr_we = 1'b0; priv_mode = old;
    endtask

    task automatic ipi(input logic v);
        ipi_we = 1'b1; ipi_wdata = v;
        tick(1);
        ipi_we = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 pend", {20'd0, pend_o}, 32'h0);
        chk("R1 ena", {20'd0, ena_o}, 32'h0);
        chk("R1 exc", {31'd0, exc_go}, 32'h0);
        chk_sel("R1", 1'b0, 4'd0);
    endtask

    task automatic t_lines();
        do_reset();
        ext_m_line = 1; mtimer_line = 1;
        tick(1);
        chk("R2 m lines", {20'd0, pend_o}, 32'h880);
        csr_wr(1'b0, PM, 12'h000);
        chk("R2 csr clear ignored", {20'd0, pend_o}, 32'h880);
        ext_s_line = 1; ext_u_line = 1;
        tick(1);
        chk("R2 all lines", {20'd0, pend_o}, 32'hB80);
        ext_m_line = 0; ext_s_line = 0; ext_u_line = 0; mtimer_line = 0;
        tick(1);
        chk("R2 lines low", {20'd0, pend_o}, 32'h0);
        csr_wr(1'b0, PM, 12'hB80);
        chk("R2 csr set ignored", {20'd0, pend_o}, 32'h0);
    endtask

    task automatic t_sw_pend();
        do_reset();
        csr_wr(1'b0, PM, 12'hFFF);
        chk("R3 M write", {20'd0, pend_o}, 32'h033);
        csr_wr(1'b0, PS, 12'h000);
        chk("R3 S write", {20'd0, pend_o}, 32'h030);
        csr_wr(1'b0, PU, 12'h003);
        chk("R3 U write", {20'd0, pend_o}, 32'h030);
        csr_wr(1'b0, PS, 12'h0F2);
        chk("R3 S partial", {20'd0, pend_o}, 32'h032);
    endtask

    task automatic t_ipi();
        do_reset();
        ipi(1'b1);
        chk("R4 ipi set", {20'd0, pend_o}, 32'h008);
        csr_wr(1'b0, PM, 12'h000);
        chk("R4 csr cannot clear msw", {20'd0, pend_o}, 32'h008);
        ipi(1'b0);
        chk("R4 ipi clear", {20'd0, pend_o}, 32'h0);
    endtask

    task automatic t_enable();
        do_reset();
        csr_wr(1'b1, PM, 12'hFFF);
        chk("R5 M write", {20'd0, ena_o}, 32'hBBB);
        csr_wr(1'b1, PS, 12'h000);
        chk("R5 S ignored", {20'd0, ena_o}, 32'hBBB);
        csr_wr(1'b1, PU, 12'h000);
        chk("R5 U ignored", {20'd0, ena_o}, 32'hBBB);
        csr_wr(1'b1, PM, 12'h0F0);
        chk("R5 masked", {20'd0, ena_o}, 32'h0B0);
    endtask

    task automatic t_gating();
        do_reset();
        csr_wr(1'b1, PM, 12'hFFF);
        csr_wr(1'b0, PM, 12'h001);
        tick(2);
        chk_sel("R6 same mode ie off", 1'b0, 4'd0);
        glb_ie = 3'b001; tick(1);
        chk_sel("R6 same mode ie on", 1'b1, 4'd0);
        priv_mode = PS; tick(1);
        chk_sel("R6 below masked", 1'b0, 4'd0);
        csr_wr(1'b0, PM, 12'h002);
        priv_mode = PU; glb_ie = 3'b000; tick(2);
        chk_sel("R6 above always on", 1'b1, 4'd1);
        priv_mode = PM; glb_ie = 3'b011; tick(1);
        chk_sel("R6 S masked in M", 1'b0, 4'd0);
        csr_wr(1'b0, PM, 12'h000);
        ipi(1'b1);
        tick(1);
        chk_sel("R6 M ie off", 1'b0, 4'd0);
        glb_ie = 3'b100; tick(1);
        chk_sel("R6 M ie on", 1'b1, 4'd3);
        csr_wr(1'b1, PM, 12'h000);
        tick(1);
        chk_sel("R6 enable cleared", 1'b0, 4'd0);
    endtask

    task automatic t_prio();
        do_reset();
        csr_wr(1'b1, PM, 12'hFFF);
        ext_m_line = 1; ext_s_line = 1; ext_u_line = 1; mtimer_line = 1;
        csr_wr(1'b0, PM, 12'h033);
        ipi(1'b1);
        tick(2);
        chk_sel("R7 all pending", 1'b1, 4'd11);
        ext_m_line = 0; tick(2);
        chk_sel("R7 s ext", 1'b1, 4'd9);
        ext_s_line = 0; tick(2);
        chk_sel("R7 m sw over hidden u ext", 1'b1, 4'd3);
        glb_ie = 3'b001; tick(2);
        chk_sel("R7 u ext over sw", 1'b1, 4'd8);
        ext_u_line = 0; tick(2);
        chk_sel("R7 m sw", 1'b1, 4'd3);
        ipi(1'b0); tick(2);
        chk_sel("R7 s sw", 1'b1, 4'd1);
        csr_wr(1'b0, PM, 12'h031); tick(2);
        chk_sel("R7 u sw over timer", 1'b1, 4'd0);
        csr_wr(1'b0, PM, 12'h030); tick(2);
        chk_sel("R7 m timer", 1'b1, 4'd7);
        mtimer_line = 0; tick(2);
        chk_sel("R7 s timer", 1'b1, 4'd5);
        csr_wr(1'b0, PM, 12'h010); tick(2);
        chk_sel("R7 u timer", 1'b1, 4'd4);
        csr_wr(1'b0, PM, 12'h000); tick(2);
        chk_sel("R10 none", 1'b0, 4'd0);
    endtask

    task automatic t_latency();
        do_reset();
        csr_wr(1'b1, PM, 12'hFFF);
        ipi(1'b1);
        chk({"R8 pend seen"}, {31'd0, pend_o[3]}, 32'h1);
        chk_sel("R8 not yet", 1'b0, 4'd0);
        tick(1);
        chk_sel("R8 one later", 1'b1, 4'd3);
        tick(1);
        chk_sel("R8 held", 1'b1, 4'd3);
        priv_mode = PM; tick(1);
        chk_sel("R8 mode change one edge", 1'b0, 4'd0);
    endtask

    task automatic t_exc();
        do_reset();
        exc_pending = 1'b1;
        tick(1);
        chk("R9 exc alone", {31'd0, exc_go}, 32'h1);
        chk_sel("R9 exc alone", 1'b0, 4'd0);
        csr_wr(1'b1, PM, 12'hFFF);
        ipi(1'b1);
        tick(1);
        chk("R9 exc suppressed", {31'd0, exc_go}, 32'h0);
        chk_sel("R9 irq wins", 1'b1, 4'd3);
        exc_pending = 1'b0;
        ipi(1'b0);
        tick(1);
        chk("R9 exc idle", {31'd0, exc_go}, 32'h0);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_lines();
        t_sw_pend();
        t_ipi();
        t_enable();
        t_gating();
        t_prio();
        t_latency();
        t_exc();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule